// File: doc/BRIEF.md
# Pipelined Bit-Scan and Population-Count Unit

This execution unit takes one operand per clock together with a three-bit operation code. It returns one of five results: the number of set bits, the index of the lowest set bit, the index of the highest set bit, the number of trailing zeros or the number of leading zeros. Each result comes with a zero flag and a carry flag. Every operation spends exactly three clock cycles in the unit, whatever the operand value is. The unit never stalls, so a new operation can enter on every cycle.

All five operations share a single adder tree. For the scan and zero-count operations, a pre-encode step first turns the operand into a mask of the bits below its first set bit, so the tree's count is that bit's position. A reverse scan or a leading-zero count runs the same step on the bit-reversed operand. A narrow mode looks only at the lower half of the operand.

A scan of a zero operand has no index to report. In that case the unit passes through the previous destination value, which the issuing logic supplies alongside the operand. The zero-count operations are defined for every input and return the effective width when the operand is zero.

Top module: `bitcount_unit`

## Requirements
- R1: Operation code 0 returns the number of set bits in the effective operand. The zero flag is 1 exactly when that operand is zero. The carry flag is 0.
- R2: Operation code 1 on a nonzero effective operand returns the index of its lowest set bit, with both flags 0.
- R3: Operation code 2 on a nonzero effective operand returns the index of its highest set bit, with both flags 0.
- R4: Operation code 1 or 2 on a zero effective operand returns the previous destination input unchanged, with the zero flag at 1 and the carry flag at 0.
- R5: Operation code 3 returns the number of zero bits below the lowest set bit, or the effective width when the operand is zero. The carry flag is 1 exactly when the operand is zero. The zero flag is 1 exactly when the result is 0. The previous destination value has no effect.
- R6: Operation code 4 returns the number of zero bits above the highest set bit within the effective width, or the effective width when the operand is zero. Its flags follow the same rules as R5. The previous destination value has no effect.
- R7: When the narrow input is 1, the effective width is WIDTH/2: only operand bits [WIDTH/2-1:0] are used, and count and index results are zero-extended. When the narrow input is 0, the effective width is WIDTH.
- R8: An operation presented with the input valid high appears on the outputs, with the output valid high, exactly three rising edges later. The output valid is low in any cycle that matches an idle input cycle three edges earlier. Back-to-back operations are accepted every cycle.
- R9: Operation codes 5, 6 and 7 behave exactly as operation code 0.
- R10: While reset is asserted, the output valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| in_op | input | 3 | Operation code |
| in_narrow | input | 1 | Use the lower half of the operand only |
| in_operand | input | WIDTH | Source operand |
| in_old | input | WIDTH | Previous destination value |
| out_valid | output | 1 | Result present this cycle |
| out_result | output | WIDTH | Result value |
| out_zf | output | 1 | Zero flag |
| out_cf | output | 1 | Carry flag |

## Verification
Two behaviours can sit in neighbouring pipeline stages and leave the unit in consecutive cycles. The first is a scan of a zero operand, which must pass the old destination through. The second is a zero count of that same operand, which must ignore the old destination and report the width with carry set. The bench provokes this with a sweep whose innermost loop steps the operation code at a fixed operand, in both width modes, and supplies a fresh old destination value on every issue. Each output cycle is judged against an arithmetic loop model, together with the output valid expected three edges after issue, so a mix-up between the pass-through path and the count path shows up in the cycle where it happens.

// File: rtl/bc_pkg.sv
package bc_pkg;

  typedef enum logic [2:0] {
    K_POP = 3'd0,
    K_FWD = 3'd1,
    K_REV = 3'd2,
    K_TZ  = 3'd3,
    K_LZ  = 3'd4
  } bc_kind_e;

  // Codes 5..7 fold onto the population count.
  function automatic bc_kind_e decode_op(input logic [2:0] op);
    case (op)
      3'd1:    decode_op = K_FWD;
      3'd2:    decode_op = K_REV;
      3'd3:    decode_op = K_TZ;
      3'd4:    decode_op = K_LZ;
      default: decode_op = K_POP;
    endcase
  endfunction

endpackage

// File: rtl/bc_preenc.sv
module bc_preenc
  import bc_pkg::*;
#(
  parameter int WIDTH = 64
) (
  input  logic [2:0]       op,
  input  logic             narrow,
  input  logic [WIDTH-1:0] operand,
  output bc_kind_e         kind,
  output logic [WIDTH-1:0] vec,
  output logic             zero
);
  localparam int HALF = WIDTH / 2;
  localparam logic [WIDTH-1:0] ONE  = {{(WIDTH-1){1'b0}}, 1'b1};
  localparam logic [WIDTH-1:0] LOWM = {{(WIDTH-HALF){1'b0}}, {HALF{1'b1}}};

  logic [WIDTH-1:0] mask, xm, rv, rs, src, iso, below;

  assign mask = narrow ? LOWM : '1;
  assign xm   = operand & mask;

  // Bit reversal, then realign the lower half in narrow mode.
  for (genvar i = 0; i < WIDTH; i++) begin : g_rev
    assign rv[i] = xm[WIDTH-1-i];
  end
  assign rs = narrow ? (rv >> HALF) : rv;

  always_comb begin
    kind  = decode_op(op);
    src   = (kind == K_REV || kind == K_LZ) ? rs : xm;
    iso   = src & (~src + ONE);       // lowest set bit alone
    below = (iso - ONE) & mask;       // ones under it; all ones if zero
    vec   = (kind == K_POP) ? xm : below;
    zero  = (xm == '0);
  end

endmodule

// File: rtl/bc_tree.sv
module bc_tree #(
  parameter int WIDTH  = 64,
  parameter int LEVELS = $clog2(WIDTH),
  parameter int CW     = LEVELS + 1
) (
  input  logic [WIDTH-1:0] vec,
  output logic [CW-1:0]    count
);
  // Balanced adder tree, one generate level per halving.
  for (genvar l = 0; l <= LEVELS; l++) begin : g_lvl
    localparam int N = WIDTH >> l;
    logic [CW-1:0] s [N];
    for (genvar i = 0; i < N; i++) begin : g_n
      if (l == 0) begin : g_leaf
        assign s[i] = {{(CW-1){1'b0}}, vec[i]};
      end else begin : g_sum
        assign s[i] = g_lvl[l-1].s[2*i] + g_lvl[l-1].s[2*i+1];
      end
    end
  end

  assign count = g_lvl[LEVELS].s[0];

endmodule

// File: rtl/bc_finish.sv
module bc_finish
  import bc_pkg::*;
#(
  parameter int WIDTH = 64,
  parameter int CW    = $clog2(WIDTH) + 1
) (
  input  bc_kind_e         kind,
  input  logic             narrow,
  input  logic             zero,
  input  logic [WIDTH-1:0] old,
  input  logic [CW-1:0]    count,
  output logic [WIDTH-1:0] result,
  output logic             zf,
  output logic             cf
);
  localparam logic [CW-1:0] EW_FULL = CW'(WIDTH);
  localparam logic [CW-1:0] EW_HALF = CW'(WIDTH / 2);
  localparam logic [CW-1:0] C_ONE   = CW'(1);

  logic [CW-1:0]    ew, idx;
  logic [WIDTH-1:0] cnt_x, idx_x;

  assign ew    = narrow ? EW_HALF : EW_FULL;
  assign idx   = ew - C_ONE - count;
  assign cnt_x = {{(WIDTH-CW){1'b0}}, count};
  assign idx_x = {{(WIDTH-CW){1'b0}}, idx};

  always_comb begin
    result = cnt_x;
    zf     = zero;
    cf     = 1'b0;
    case (kind)
      K_FWD: result = zero ? old : cnt_x;
      K_REV: result = zero ? old : idx_x;
      K_TZ, K_LZ: begin
        cf = zero;
        zf = (count == '0);
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/bitcount_unit.sv
module bitcount_unit
  import bc_pkg::*;
#(
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [2:0]       in_op,
  input  logic             in_narrow,
  input  logic [WIDTH-1:0] in_operand,
  input  logic [WIDTH-1:0] in_old,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_result,
  output logic             out_zf,
  output logic             out_cf
);
  localparam int CW = $clog2(WIDTH) + 1;

  // Stage 1: pre-encode
  bc_kind_e         p_kind;
  logic [WIDTH-1:0] p_vec;
  logic             p_zero;

  bc_preenc #(.WIDTH(WIDTH)) u_pre (
    .op(in_op), .narrow(in_narrow), .operand(in_operand),
    .kind(p_kind), .vec(p_vec), .zero(p_zero)
  );

  logic             v1_q, v2_q, v3_q;
  bc_kind_e         k1_q, k2_q;
  logic             n1_q, n2_q, z1_q, z2_q;
  logic [WIDTH-1:0] vec1_q, old1_q, old2_q;
  logic [CW-1:0]    cnt2_q;
  logic [WIDTH-1:0] res3_q;
  logic             zf3_q, cf3_q;

  // Stage 2: shared counting tree
  logic [CW-1:0] t_count;
  bc_tree #(.WIDTH(WIDTH)) u_tree (.vec(vec1_q), .count(t_count));

  // Stage 3: result selection and flags
  logic [WIDTH-1:0] f_result;
  logic             f_zf, f_cf;
  bc_finish #(.WIDTH(WIDTH)) u_fin (
    .kind(k2_q), .narrow(n2_q), .zero(z2_q), .old(old2_q), .count(cnt2_q),
    .result(f_result), .zf(f_zf), .cf(f_cf)
  );

  // Next-state: clock enables per stage
  logic en1, en2, en3;
  always_comb begin
    en1 = in_valid;
    en2 = v1_q;
    en3 = v2_q;
  end

  // Valid chain, reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
      v3_q <= 1'b0;
    end else begin
      v1_q <= in_valid;
      v2_q <= v1_q;
      v3_q <= v2_q;
    end
  end

  // Data registers, no reset, loaded under enable
  always_ff @(posedge clk) begin
    if (en1) begin
      k1_q   <= p_kind;
      n1_q   <= in_narrow;
      z1_q   <= p_zero;
      vec1_q <= p_vec;
      old1_q <= in_old;
    end
    if (en2) begin
      k2_q   <= k1_q;
      n2_q   <= n1_q;
      z2_q   <= z1_q;
      old2_q <= old1_q;
      cnt2_q <= t_count;
    end
    if (en3) begin
      res3_q <= f_result;
      zf3_q  <= f_zf;
      cf3_q  <= f_cf;
    end
  end

  assign out_valid  = v3_q;
  assign out_result = res3_q;
  assign out_zf     = zf3_q;
  assign out_cf     = cf3_q;

endmodule

// File: rtl/bc_check.sv
module bc_check #(
  parameter int WIDTH = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [2:0]       in_op,
  input logic             in_narrow,
  input logic [WIDTH-1:0] in_operand,
  input logic [WIDTH-1:0] in_old,
  input logic             out_valid,
  input logic [WIDTH-1:0] out_result,
  input logic             out_zf,
  input logic             out_cf
);
  localparam int IW = $clog2(WIDTH);
  localparam logic [WIDTH-1:0] EWF = WIDTH'(WIDTH);
  localparam logic [WIDTH-1:0] EWH = WIDTH'(WIDTH / 2);

  logic [1:0]       warm_cnt;
  logic             warm;
  logic [2:0]       d_op  [3];
  logic             d_nar [3];
  logic [WIDTH-1:0] d_x   [3];
  logic [WIDTH-1:0] d_old [3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm_cnt <= 2'd0;
    else if (warm_cnt != 2'd3) warm_cnt <= warm_cnt + 2'd1;
  end
  assign warm = (warm_cnt == 2'd3);

  always_ff @(posedge clk) begin
    d_op[0] <= in_op;     d_nar[0] <= in_narrow;
    d_x[0]  <= in_operand; d_old[0] <= in_old;
    for (int i = 1; i < 3; i++) begin
      d_op[i] <= d_op[i-1]; d_nar[i] <= d_nar[i-1];
      d_x[i]  <= d_x[i-1];  d_old[i] <= d_old[i-1];
    end
  end

  logic [WIDTH-1:0] ew;
  logic             is_cnt, is_scan;
  assign ew      = d_nar[2] ? EWH : EWF;
  assign is_cnt  = (d_op[2] == 3'd3) || (d_op[2] == 3'd4);
  assign is_scan = (d_op[2] == 3'd1) || (d_op[2] == 3'd2);

  // R8: fixed three-edge latency
  assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> (out_valid == $past(in_valid, 3)));

  // R4: zero-operand scan keeps the old destination
  assert_scan_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && is_scan && out_zf) |-> (out_result == d_old[2] && !out_cf));

  // R2: forward scan points at a set bit inside the effective width
  assert_fwd_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && d_op[2] == 3'd1 && !out_zf) |->
      (out_result < ew && d_x[2][out_result[IW-1:0]]));

  // R5/R6: carry on a count means the width was returned
  assert_cnt_carry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && is_cnt && out_cf) |-> (out_result == ew));

  // R1: popcount never sets carry; zero flag tracks a zero count
  assert_pop_flags_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !is_cnt && !is_scan) |-> (!out_cf && (out_zf == (out_result == '0))));

  // R10: no output during reset
  always @(posedge clk) begin
    if (!rst_n) assert_reset_idle_R10: assert (!out_valid);
  end

endmodule

bind bitcount_unit bc_check #(.WIDTH(WIDTH)) u_bc_check (.*);

// File: tb/test_bitcount_unit.sv
`timescale 1ns/1ps
module test_bitcount_unit;
  localparam int BW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic [2:0]    in_op;
  logic          in_narrow;
  logic [BW-1:0] in_operand, in_old;
  logic          out_valid;
  logic [BW-1:0] out_result;
  logic          out_zf, out_cf;

  always #2 clk = ~clk;

  bitcount_unit #(.WIDTH(BW)) i_bitcount_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_narrow(in_narrow), .in_operand(in_operand), .in_old(in_old),
    .out_valid(out_valid), .out_result(out_result), .out_zf(out_zf), .out_cf(out_cf)
  );

  int    n_chk = 0, n_bad = 0;
  bit    done = 1'b0;
  logic          pv [3];
  logic [BW-1:0] pr [3];
  logic          pz [3], pc [3];
  string         pt [3];

  // Loop model of the requirements
  task automatic model(input logic [2:0] op, input logic nar, input logic [BW-1:0] x,
                       input logic [BW-1:0] old, output logic [BW-1:0] r,
                       output logic zf, output logic cf, output string tag);
    int ew = nar ? BW/2 : BW;
    int cnt = 0, lo = -1, hi = -1;
    for (int i = 0; i < ew; i++) begin
      if (x[i]) begin
        cnt++;
        if (lo < 0) lo = i;
        hi = i;
      end
    end
    cf = 1'b0;
    zf = (cnt == 0);
    case (op)
      3'd1: begin tag = (cnt == 0) ? "R4" : "R2"; r = (cnt == 0) ? old : BW'(lo); end
      3'd2: begin tag = (cnt == 0) ? "R4" : "R3"; r = (cnt == 0) ? old : BW'(hi); end
      3'd3: begin tag = "R5"; r = (cnt == 0) ? BW'(ew) : BW'(lo);
                  cf = (cnt == 0); zf = (r == 0); end
      3'd4: begin tag = "R6"; r = (cnt == 0) ? BW'(ew) : BW'(ew - 1 - hi);
                  cf = (cnt == 0); zf = (r == 0); end
      3'd0:    begin tag = "R1"; r = BW'(cnt); end
      default: begin tag = "R9"; r = BW'(cnt); end
    endcase
    if (nar) tag = {tag, "/R7"};
  endtask

  // One clock: check the oldest slot, shift, issue
  task automatic step(input logic v, input logic [2:0] op, input logic nar,
                      input logic [BW-1:0] x, input logic [BW-1:0] old);
    logic [BW-1:0] r; logic zf, cf; string tag;
    @(negedge clk);
    n_chk++;
    if (out_valid !== pv[2]) begin
      n_bad++;
      $display("FAIL R8 out_valid actual %b expected %b", out_valid, pv[2]);
    end else if (pv[2]) begin
      n_chk++;
      if (out_result !== pr[2] || out_zf !== pz[2] || out_cf !== pc[2]) begin
        n_bad++;
        $display("FAIL %s result/zf/cf actual %h/%b/%b expected %h/%b/%b",
                 pt[2], out_result, out_zf, out_cf, pr[2], pz[2], pc[2]);
      end
    end
    for (int i = 2; i > 0; i--) begin
      pv[i] = pv[i-1]; pr[i] = pr[i-1]; pz[i] = pz[i-1]; pc[i] = pc[i-1]; pt[i] = pt[i-1];
    end
    model(op, nar, x, old, r, zf, cf, tag);
    pv[0] = v; pr[0] = r; pz[0] = zf; pc[0] = cf; pt[0] = tag;
    in_valid = v; in_op = op; in_narrow = nar; in_operand = x; in_old = old;
  endtask

  initial begin
    for (int i = 0; i < 3; i++) begin pv[i] = 1'b0; pr[i] = '0; pz[i] = 0; pc[i] = 0; pt[i] = ""; end
    rst_n = 1'b0; in_valid = 1'b0; in_op = '0; in_narrow = 1'b0;
    in_operand = '0; in_old = '0;
    repeat (3) @(negedge clk);
    n_chk++;
    if (out_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R10 out_valid in reset actual %b expected 0", out_valid);
    end
    rst_n = 1'b1;
    // Exhaustive sweep; opcode innermost so one operand meets every path back to back
    for (int nar = 0; nar < 2; nar++) begin
      for (int x = 0; x < (1 << BW); x++) begin
        for (int op = 0; op < 8; op++) begin
          step(1'b1, 3'(op), 1'(nar), BW'(x), BW'($urandom));
        end
        if (x % 5 == 4) step(1'b0, 3'd0, 1'b0, '0, '0);   // idle gap, R8
      end
    end
    repeat (4) step(1'b0, 3'd0, 1'b0, '0, '0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule